// File: doc/BRIEF.md
# Three-Channel Interval Timer Register Interface

This block is the host-facing register front end of a three-channel interval timer. A host reaches it through one 8-bit port with a 2-bit offset. Offsets 0, 1 and 2 are the data ports of channels 0, 1 and 2. Offset 3 takes command bytes. The block decodes those commands, keeps each channel's access width, mode and number format, and splits the 16-bit count values into byte transfers in both directions.

Toward each counter the block drives a one-cycle load strobe, the 16-bit load value, the 3-bit mode and the BCD flag. From each counter it samples three things: the live count, the output pin and the "count loaded" flag. The host can freeze a channel's count in a snapshot. It can freeze the counts of several channels with one command, or capture a status byte per channel. A frozen value stays in place until the host has read it out. The counting itself lives in the channel logic outside this block.

Top module: `pit_regif`

## Requirements
- R1: After reset every channel uses 16-bit access (low byte first), mode 0 and binary format, and no load strobe is active. A read of a data port returns the live count of that channel.
- R2: A command byte selects a channel with bits 7..6 (values 0..2). When bits 5..4 are nonzero they set the access width: 01 low byte only, 10 high byte only, 11 low then high. In that case bits 3..1 become the channel mode and bit 0 the BCD flag (1 = BCD). The mode and BCD outputs show the new values from the cycle after the write.
- R3: In low-byte-only access, one data write strobes the channel, with the written byte as the low byte and zero as the high byte.
- R4: In high-byte-only access, one data write strobes the channel, with the written byte as the high byte and zero as the low byte.
- R5: In 16-bit access the first data write is held and does not strobe. The second write strobes the value {second byte, first byte}.
- R6: In 16-bit access, reads return the low byte and then the high byte. In a single-byte access mode, every read returns the one selected byte.
- R7: A command with bits 5..4 = 00 snapshots the channel's count, and reads then return the snapshot. Further such commands to that channel are ignored until the snapshot has been fully read, and the mode bits of the command have no effect on the mode output.
- R8: A command that sets the access width restarts the channel's write and read byte sequence at the low byte and discards any held snapshot.
- R9: Command nibble 1101 snapshots the count of every channel whose bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2. A channel that already holds a snapshot keeps it.
- R10: Command nibble 1110 captures a status byte for every channel selected by the same bits 1..3. The byte is: bit 7 output pin, bit 6 count-loaded flag, bits 5..4 access width (01 high only, 10 low only, 11 both), bits 3..1 mode, bit 0 BCD.
- R11: When a channel holds both a status byte and a count snapshot, the first read returns the status byte and the next read or reads return the count.
- R12: A read of offset 3 returns zero, and command nibbles 1100 and 1111 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port offset: 0..2 channel data, 3 command |
| wr_en | input | 1 | Write strobe for the byte on wdata |
| rd_en | input | 1 | Read strobe; advances the read sequence at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |
| ld_stb | output | NCH | Per-channel one-cycle load strobe |
| ld_val | output | 16*NCH | Per-channel load value, channel i in bits 16i+15..16i |
| ch_mode | output | 3*NCH | Per-channel mode, channel i in bits 3i+2..3i |
| ch_bcd | output | NCH | Per-channel BCD flag |
| cnt_in | input | 16*NCH | Live count from each channel |
| out_pin | input | NCH | Output pin level of each channel |
| loaded | input | NCH | Count-loaded flag of each channel |

## Verification
A wrong byte pointer shows on the next data transfer. Read data comes back with its bytes swapped, or a load strobe appears one write early or one write late. A latch flag that is set or cleared at the wrong time appears within one or two reads: the host sees a live count where it expects a frozen one, or a stale snapshot after the read sequence is complete. Errors in the status byte and in its priority over the count show on the first read after the status command. Each scenario therefore reads every byte it expects and one more byte past the end of the sequence.

// File: rtl/pit_regif.sv
module pit_regif #(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NCH-1:0]    ld_stb,
  output logic [16*NCH-1:0] ld_val,
  output logic [3*NCH-1:0]  ch_mode,
  output logic [NCH-1:0]    ch_bcd,
  input  logic [16*NCH-1:0] cnt_in,
  input  logic [NCH-1:0]    out_pin,
  input  logic [NCH-1:0]    loaded
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic [NCH-1:0][1:0]  acc;
  logic [NCH-1:0][2:0]  mode_r;
  logic [NCH-1:0]       bcd_r;
  logic [NCH-1:0]       wr_ptr, rd_ptr, cnt_lat, st_lat;
  logic [NCH-1:0][7:0]  lo_hold, st_val;
  logic [NCH-1:0][15:0] lat_val, val_r, src;
  logic [NCH-1:0]       rd_hit, wr_hit, cmd_ch, ml_hit, ms_hit;

  wire cmd_wr = wr_en && addr == CMD_ADDR;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rd_hit[i] = rd_en && addr == 2'(i);
    assign wr_hit[i] = wr_en && addr == 2'(i);
    assign cmd_ch[i] = cmd_wr && wdata[7:6] == 2'(i);
    assign ml_hit[i] = cmd_wr && wdata[7:4] == 4'hD && wdata[i+1];
    assign ms_hit[i] = cmd_wr && wdata[7:4] == 4'hE && wdata[i+1];
    assign src[i]    = cnt_lat[i] ? lat_val[i] : cnt_in[16*i +: 16];
    assign ld_val[16*i +: 16] = val_r[i];
    assign ch_mode[3*i +: 3]  = mode_r[i];
    assign ch_bcd[i]          = bcd_r[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '1; mode_r <= '0; bcd_r <= '0;
      wr_ptr <= '0; rd_ptr <= '0; cnt_lat <= '0; st_lat <= '0;
      lo_hold <= '0; st_val <= '0; lat_val <= '0; val_r <= '0;
      ld_stb <= '0;
    end else begin
      ld_stb <= '0;
      for (int i = 0; i < NCH; i++) begin
        if (rd_hit[i]) begin
          if (st_lat[i]) st_lat[i] <= 1'b0;
          else if (acc[i] == 2'b11 && !rd_ptr[i]) rd_ptr[i] <= 1'b1;
          else begin
            rd_ptr[i]  <= 1'b0;
            cnt_lat[i] <= 1'b0;
          end
        end
        if (wr_hit[i]) begin
          case (acc[i])
            2'b01: begin ld_stb[i] <= 1'b1; val_r[i] <= {8'h00, wdata}; end
            2'b10: begin ld_stb[i] <= 1'b1; val_r[i] <= {wdata, 8'h00}; end
            default:
              if (!wr_ptr[i]) begin
                lo_hold[i] <= wdata;
                wr_ptr[i]  <= 1'b1;
              end else begin
                ld_stb[i]  <= 1'b1;
                val_r[i]   <= {wdata, lo_hold[i]};
                wr_ptr[i]  <= 1'b0;
              end
          endcase
        end
        if (((cmd_ch[i] && wdata[5:4] == 2'b00) || ml_hit[i]) && !cnt_lat[i]) begin
          cnt_lat[i] <= 1'b1;
          lat_val[i] <= cnt_in[16*i +: 16];
          rd_ptr[i]  <= 1'b0;
        end
        if (cmd_ch[i] && wdata[5:4] != 2'b00) begin
          acc[i]     <= wdata[5:4];
          mode_r[i]  <= wdata[3:1];
          bcd_r[i]   <= wdata[0];
          wr_ptr[i]  <= 1'b0;
          rd_ptr[i]  <= 1'b0;
          cnt_lat[i] <= 1'b0;
          st_lat[i]  <= 1'b0;
        end
        if (ms_hit[i] && !st_lat[i]) begin
          st_lat[i] <= 1'b1;
          st_val[i] <= {out_pin[i], loaded[i], acc[i][0], acc[i][1], mode_r[i], bcd_r[i]};
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) begin
        if (st_lat[i]) rdata = st_val[i];
        else case (acc[i])
          2'b01:   rdata = src[i][7:0];
          2'b10:   rdata = src[i][15:8];
          default: rdata = rd_ptr[i] ? src[i][15:8] : src[i][7:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_regif_chk.sv
module pit_regif_chk #(
  parameter int NCH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          addr,
  input logic                wr_en,
  input logic                rd_en,
  input logic [7:0]          wdata,
  input logic [7:0]          rdata,
  input logic [NCH-1:0]      ld_stb,
  input logic [16*NCH-1:0]   ld_val,
  input logic [3*NCH-1:0]    ch_mode,
  input logic [NCH-1:0]      ch_bcd,
  input logic [NCH-1:0]      out_pin,
  input logic [NCH-1:0]      loaded,
  input logic [NCH-1:0][1:0] acc,
  input logic [NCH-1:0]      st_lat
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R5
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb[i] |-> $past(wr_en && addr == 2'(i)));
    // R2
    mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'b00)
      |-> (ch_mode[3*i +: 3] == $past(wdata[3:1]) && ch_bcd[i] == $past(wdata[0])));
    // R4
    high_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb[i] && acc[i] == 2'b10) |-> ld_val[16*i +: 8] == 8'h00);
    // R10
    status_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en && addr == 2'd3 && wdata[7:4] == 4'hE && wdata[i+1] && !st_lat[i])
       && addr == 2'(i))
      |-> rdata[7:6] == {$past(out_pin[i]), $past(loaded[i])});
  end
endmodule

bind pit_regif pit_regif_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/pit_regif_tb.sv
`timescale 1ns/1ps
module pit_regif_tb;
  localparam int NCH = 3;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [NCH-1:0] ld_stb, ch_bcd;
  logic [16*NCH-1:0] ld_val, cnt_in = 0;
  logic [3*NCH-1:0] ch_mode;
  logic [NCH-1:0] out_pin = 0, loaded = 0;
  int n_chk = 0, n_fail = 0;
  logic [NCH-1:0] stb_cap;
  logic [16*NCH-1:0] val_cap;
  logic [7:0] rv;

  always #5 clk = ~clk;

  pit_regif #(.NCH(NCH)) u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1; stb_cap = ld_stb; val_cap = ld_val; wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1; v = rdata;
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 mode", ch_mode, 0); chk("R1 bcd", ch_bcd, 0); chk("R1 stb", ld_stb, 0);
    cnt_in[15:0] = 16'hA55A;
    rd(0, rv); chk("R1 rd lo", rv, 8'h5A);
    rd(0, rv); chk("R1 rd hi", rv, 8'hA5);
  endtask

  task automatic t_modes;
    wr(3, 8'b0001_0101);
    chk("R2 mode0", ch_mode[2:0], 2); chk("R2 bcd0", ch_bcd[0], 1);
    wr(0, 8'h37); chk("R3 stb", stb_cap, 3'b001); chk("R3 val", val_cap[15:0], 16'h0037);
    cnt_in[15:0] = 16'h1234;
    rd(0, rv); chk("R6 lo-only a", rv, 8'h34);
    rd(0, rv); chk("R6 lo-only b", rv, 8'h34);
    wr(3, 8'b0110_0110);
    chk("R2 mode1", ch_mode[5:3], 3); chk("R2 bcd1", ch_bcd[1], 0);
    wr(1, 8'h9C); chk("R4 stb", stb_cap, 3'b010); chk("R4 val", val_cap[31:16], 16'h9C00);
    cnt_in[31:16] = 16'hBEEF;
    rd(1, rv); chk("R6 hi-only", rv, 8'hBE);
    wr(3, 8'b1011_1000); chk("R2 mode2", ch_mode[8:6], 4);
    wr(2, 8'h11); chk("R5 first no stb", stb_cap, 0);
    wr(2, 8'h22); chk("R5 stb", stb_cap, 3'b100); chk("R5 val", val_cap[47:32], 16'h2211);
  endtask

  task automatic t_latch;
    cnt_in[47:32] = 16'h4321;
    wr(3, 8'b1000_1010); chk("R7 mode kept", ch_mode[8:6], 4);
    cnt_in[47:32] = 16'h9999;
    wr(3, 8'b1000_0000);
    rd(2, rv); chk("R7 lat lo", rv, 8'h21);
    cnt_in[47:32] = 16'h8888;
    wr(3, 8'b1000_0000);
    rd(2, rv); chk("R7 lat hi", rv, 8'h43);
    rd(2, rv); chk("R7 live after", rv, 8'h88);
    rd(2, rv);
  endtask

  task automatic t_ptr;
    wr(2, 8'h55);
    wr(3, 8'b1011_0000); chk("R8 mode", ch_mode[8:6], 0);
    wr(2, 8'h66); chk("R8 no stb", stb_cap, 0);
    wr(2, 8'h77); chk("R8 val", val_cap[47:32], 16'h7766);
    cnt_in[47:32] = 16'hABCD;
    rd(2, rv); chk("R8 rd lo", rv, 8'hCD);
    wr(3, 8'b1011_0000);
    rd(2, rv); chk("R8 rd restart", rv, 8'hCD);
    rd(2, rv);
    wr(3, 8'b1000_0000);
    wr(3, 8'b1011_0000);
    cnt_in[47:32] = 16'h3C3C;
    rd(2, rv); chk("R8 lat dropped", rv, 8'h3C);
    rd(2, rv);
  endtask

  task automatic t_multi;
    cnt_in = {16'h0102, 16'h0304, 16'h0506};
    wr(3, 8'b1101_0110);
    cnt_in = {16'hF1F2, 16'hF3F4, 16'hF5F6};
    rd(0, rv); chk("R9 ch0", rv, 8'h06);
    rd(1, rv); chk("R9 ch1", rv, 8'h03);
    rd(2, rv); chk("R9 ch2 live", rv, 8'hF2);
    rd(2, rv);
    rd(0, rv); chk("R9 ch0 freed", rv, 8'hF6);
  endtask

  task automatic t_status;
    out_pin = 3'b101; loaded = 3'b011;
    wr(3, 8'b1110_1010);
    out_pin = 3'b000; loaded = 3'b000;
    rd(0, rv); chk("R10 ch0", rv, 8'hE5);
    rd(0, rv); chk("R10 ch0 then count", rv, 8'hF6);
    rd(2, rv); chk("R10 ch2", rv, 8'hB0);
  endtask

  task automatic t_prio;
    out_pin = 3'b100; loaded = 3'b000;
    cnt_in[47:32] = 16'h0F0E;
    wr(3, 8'b1000_0000);
    wr(3, 8'b1110_1000);
    cnt_in[47:32] = 16'h7777;
    rd(2, rv); chk("R11 status first", rv, 8'hB0);
    rd(2, rv); chk("R11 lo", rv, 8'h0E);
    rd(2, rv); chk("R11 hi", rv, 8'h0F);
  endtask

  task automatic t_misc;
    logic [3*NCH-1:0] m;
    m = ch_mode;
    rd(3, rv); chk("R12 cmd rd", rv, 0);
    wr(3, 8'b1100_1110);
    wr(3, 8'b1111_1110);
    chk("R12 mode kept", ch_mode, m);
    cnt_in[47:32] = 16'h2468;
    rd(2, rv); chk("R12 no latch", rv, 8'h68);
    rd(2, rv); chk("R12 no latch hi", rv, 8'h24);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_modes; t_latch; t_ptr; t_multi; t_status; t_prio; t_misc;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule